// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the power-control register of a small 8-bit microcontroller and turns its two mode requests into clock gating. A light-sleep request stops only the CPU clock while the peripherals keep running. A deep-sleep request stops the oscillator and every clock derived from it. The register also carries two general-purpose flags, a power-off flag and two serial-mode bits. These are plain storage for software.

Light sleep ends on any enabled interrupt. It also ends when an ADC conversion completes, but only if the ADC itself requested the sleep. Deep sleep ends only on an external interrupt line that is configured as level-sensitive and is held low. The clocks come back at once, but `cpu_run` stays low until every such line is released.

A high level on the reset pin clears both mode bits at once, without waiting for a clock. A full warm reset is accepted only after the pin has been sampled high on a run of consecutive oscillator cycles. The power-on pulse is the cold reset.

Top module: `pwr_mode_ctl`

## Requirements
- R1: On the power-on pulse the register reads 8'b0001_0000, `cpu_run`, `cpu_clk_en` and `periph_clk_en` are high and `warm_rst` is low. Bit 5 always reads 0, whatever is written to it.
- R2: Writing 1 to bit 0 (with bit 1 at 0) enters light sleep. One cycle after the write, `cpu_clk_en` and `cpu_run` are low and `periph_clk_en` stays high.
- R3: Writing 1 to bit 1 enters deep sleep. One cycle after the write, `cpu_clk_en` and `periph_clk_en` are both low.
- R4: A write with bits 1 and 0 both set enters deep sleep only: bits [1:0] read 2'b10. After wake-up the block returns to running and bit 0 reads 0.
- R5: While in light sleep, `irq_pend` high clears bit 0 on the next clock edge, and `cpu_run` returns high.
- R6: `adc_done` ends light sleep only when the sleep was entered through `adc_idle_req`. For a sleep written by software, `adc_done` has no effect.
- R7: Deep sleep is left only when an external line `ext_int_n[i]` is low while `ext_lvl[i]` is 1. `irq_pend` has no effect, and neither does a low line whose `ext_lvl` bit is 0.
- R8: On deep-sleep wake-up, bit 1 clears and both clock enables rise on the next edge. `cpu_run` stays low until no level-configured line is low, and rises on the edge after the release.
- R9: `rst_pin` high clears bits 1 and 0 immediately, with no clock edge.
- R10: `warm_rst` asserts only after `rst_pin` has been sampled high on RST_QUAL (default 24) consecutive clocks. A low sample restarts the count. A warm reset clears bits 7:6 and 3:2 and keeps bit 4.
- R11: Bit 4 (power-off flag) is set by the power-on pulse and can be written 0 or 1 by software. Bits 3:2 and 7:6 store the written values.
- R12: A write while `cpu_run` is low has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-on pulse, asynchronous, active high |
| rst_pin | input | 1 | Raw external reset pin, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents |
| irq_pend | input | 1 | Any enabled interrupt pending |
| adc_idle_req | input | 1 | ADC request to enter light sleep |
| adc_done | input | 1 | ADC conversion complete |
| ext_int_n | input | NEXT | External interrupt lines, active low |
| ext_lvl | input | NEXT | 1 = line is level-sensitive |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Oscillator and peripheral clock enable |
| cpu_run | output | 1 | CPU may execute |
| warm_rst | output | 1 | Qualified warm reset |

## Verification
On every cycle, the assertions check the following:
- deep sleep wins over light sleep in a combined write;
- a pending interrupt ends light sleep on the next edge;
- a level wake-up restores the clocks while holding the CPU;
- a halted CPU cannot alter the register;
- a warm reset leaves the general and serial bits cleared.

Only the bench scenarios can show the rest:
- the exact 23-versus-24 sample boundary of the reset qualifier, and its restart after a single low sample;
- the asynchronous clear between clock edges;
- that `adc_done` is ignored for a sleep written by software;
- that the CPU stays held until the wake line is released.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int RST_QUAL = 24,
  parameter int NEXT = 2
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst_pin,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic            irq_pend,
  input  logic            adc_idle_req,
  input  logic            adc_done,
  input  logic [NEXT-1:0] ext_int_n,
  input  logic [NEXT-1:0] ext_lvl,
  output logic            cpu_clk_en,
  output logic            periph_clk_en,
  output logic            cpu_run,
  output logic            warm_rst
);
  localparam int CW = $clog2(RST_QUAL + 1);
  localparam logic [CW-1:0] QMAX = CW'(RST_QUAL);

  logic idl, pd, hold, adc_idl;
  logic gf0, gf1, pof;
  logic [1:0] smod;
  logic s1, s2;
  logic [CW-1:0] cnt;

  wire wake  = |(ext_lvl & ~ext_int_n);
  wire wr_ok = wr_en && cpu_run;

  assign cpu_run       = !idl && !pd && !hold;
  assign cpu_clk_en    = !idl && !pd;
  assign periph_clk_en = !pd;
  assign rd_data       = {smod, 1'b0, pof, gf1, gf0, pd, idl};
  assign warm_rst      = (cnt == QMAX);

  always_ff @(posedge clk or posedge por or posedge rst_pin) begin
    if (por || rst_pin) begin
      idl <= 1'b0; pd <= 1'b0; hold <= 1'b0; adc_idl <= 1'b0;
    end else if (pd) begin
      if (wake) begin pd <= 1'b0; hold <= 1'b1; end
    end else if (hold) begin
      if (!wake) hold <= 1'b0;
    end else if (idl) begin
      if (irq_pend || (adc_idl && adc_done)) begin idl <= 1'b0; adc_idl <= 1'b0; end
    end else if (wr_ok) begin
      pd      <= wr_data[1];
      idl     <= wr_data[0] && !wr_data[1];
      adc_idl <= 1'b0;
    end else if (adc_idle_req) begin
      idl <= 1'b1; adc_idl <= 1'b1;
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      smod <= 2'b00; gf1 <= 1'b0; gf0 <= 1'b0; pof <= 1'b1;
    end else if (warm_rst) begin
      smod <= 2'b00; gf1 <= 1'b0; gf0 <= 1'b0;
    end else if (wr_ok) begin
      smod <= wr_data[7:6]; pof <= wr_data[4];
      gf1 <= wr_data[3]; gf0 <= wr_data[2];
    end
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      s1 <= 1'b0; s2 <= 1'b0; cnt <= '0;
    end else begin
      s1 <= rst_pin; s2 <= s1;
      if (!s2) cnt <= '0;
      else if (cnt != QMAX) cnt <= cnt + 1'b1;
    end
  end

  // R4
  both_pd_chk: assert property (@(posedge clk) disable iff (por || rst_pin)
    (wr_en && cpu_run && wr_data[1:0] == 2'b11) |=> (rd_data[1:0] == 2'b10));

  // R5
  idle_irq_exit_chk: assert property (@(posedge clk) disable iff (por || rst_pin)
    (rd_data[0] && irq_pend) |=> !rd_data[0]);

  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (por || rst_pin)
    (rd_data[1] && wake) |=> (periph_clk_en && cpu_clk_en && !cpu_run));

  // R3
  run_clk_chk: assert property (@(posedge clk) disable iff (por)
    cpu_run |-> (cpu_clk_en && periph_clk_en));

  // R12
  halted_wr_chk: assert property (@(posedge clk) disable iff (por)
    (!cpu_run && wr_en && !warm_rst) |=> $stable(rd_data[7:2]));

  // R10
  warm_clr_chk: assert property (@(posedge clk) disable iff (por)
    warm_rst |=> (rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00 && rd_data[4] == $past(rd_data[4])));
endmodule

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, por = 1'b1, rst_pin = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq_pend = 1'b0, adc_idle_req = 1'b0, adc_done = 1'b0;
  logic [1:0] ext_int_n = 2'b11, ext_lvl = 2'b00;
  logic cpu_clk_en, periph_clk_en, cpu_run, warm_rst;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl i_pwr_mode_ctl (
    .clk, .por, .rst_pin, .wr_en, .wr_data, .rd_data, .irq_pend,
    .adc_idle_req, .adc_done, .ext_int_n, .ext_lvl,
    .cpu_clk_en, .periph_clk_en, .cpu_run, .warm_rst);

  function automatic logic [7:0] exp_wr(logic [7:0] d);
    exp_wr = {d[7:6], 1'b0, d[4:2], d[1], d[0] & ~d[1]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_rst(int n);
    seen = 0;
    @(negedge clk); rst_pin = 1'b1;
    repeat (n) begin @(negedge clk); seen |= warm_rst; end
    rst_pin = 1'b0;
    repeat (4) begin @(negedge clk); seen |= warm_rst; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reg", rd_data, 8'h10);
    chk("R1 outs", {4'h0, cpu_run, cpu_clk_en, periph_clk_en, warm_rst}, 8'h0E);

    // R11 / R1 bit5: random flag writes
    for (int k = 0; k < 40; k++) begin
      d = 8'($urandom) & 8'hFC;
      wr(d);
      chk("R11 rand", rd_data, exp_wr(d));
    end

    // R2 light sleep
    wr(8'h01);
    chk("R2", {rd_data, 5'b0, cpu_clk_en, periph_clk_en, cpu_run}, {8'h01, 8'h02});
    // R12 write while halted
    wr(8'h0C);
    chk("R12", rd_data, 8'h01);
    // R5 interrupt exit
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
    chk("R5", {rd_data, 7'b0, cpu_run}, {8'h00, 8'h01});

    // R6 adc_done ignored for software sleep
    wr(8'h01);
    @(negedge clk); adc_done = 1'b1;
    @(negedge clk); adc_done = 1'b0;
    chk("R6 sw", {7'b0, rd_data[0]}, 8'h01);
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
    @(negedge clk); adc_idle_req = 1'b1;
    @(negedge clk); adc_idle_req = 1'b0;
    chk("R6 adc enter", {7'b0, rd_data[0]}, 8'h01);
    @(negedge clk); adc_done = 1'b1;
    @(negedge clk); adc_done = 1'b0;
    chk("R6 adc exit", {7'b0, rd_data[0]}, 8'h00);

    // R3 deep sleep
    wr(8'h02);
    chk("R3", {6'b0, cpu_clk_en, periph_clk_en}, 8'h00);
    // R7 ignored wake sources
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
    chk("R7 irq", {7'b0, rd_data[1]}, 8'h01);
    @(negedge clk); ext_lvl = 2'b01; ext_int_n = 2'b01;
    repeat (2) @(negedge clk);
    chk("R7 edge line", {7'b0, rd_data[1]}, 8'h01);
    // R8 level wake
    ext_lvl = 2'b11;
    @(negedge clk);
    chk("R8 wake", {rd_data[1], 4'b0, cpu_clk_en, periph_clk_en, cpu_run}, {1'b0, 7'b0000110});
    repeat (3) @(negedge clk);
    chk("R8 held", {7'b0, cpu_run}, 8'h00);
    ext_int_n = 2'b11;
    @(negedge clk);
    chk("R8 release", {7'b0, cpu_run}, 8'h01);

    // R4 combined write
    wr(8'h03);
    chk("R4 pd wins", {6'b0, rd_data[1:0]}, 8'h02);
    @(negedge clk); ext_int_n = 2'b10;
    @(negedge clk); ext_int_n = 2'b11;
    repeat (2) @(negedge clk);
    chk("R4 after wake", {6'b0, rd_data[1:0], 7'b0, cpu_run}, {8'h00, 8'h01});

    // R9 asynchronous clear
    wr(8'h02);
    @(negedge clk); rst_pin = 1'b1; #1;
    chk("R9", {6'b0, rd_data[1], periph_clk_en}, 8'h01);
    repeat (3) @(negedge clk);
    rst_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R10 qualification
    wr(8'h1C);
    pulse_rst(23);
    chk("R10 23 samples", {7'b0, seen}, 8'h00);
    chk("R10 kept", rd_data, 8'h1C);
    seen = 0;
    @(negedge clk); rst_pin = 1'b1;
    repeat (20) begin @(negedge clk); seen |= warm_rst; end
    rst_pin = 1'b0;
    @(negedge clk); seen |= warm_rst;
    rst_pin = 1'b1;
    repeat (20) begin @(negedge clk); seen |= warm_rst; end
    rst_pin = 1'b0;
    repeat (4) begin @(negedge clk); seen |= warm_rst; end
    chk("R10 restart", {7'b0, seen}, 8'h00);
    wr(8'hDC);
    pulse_rst(24);
    chk("R10 24 samples", {7'b0, seen}, 8'h01);
    chk("R10 cleared", rd_data, 8'h10);

    // R11 software clear then power-on set
    wr(8'h00);
    chk("R11 clear", rd_data, 8'h00);
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    @(negedge clk);
    chk("R11 por", rd_data, 8'h10);

    finish_run();
  end
endmodule